// File: doc/BRIEF.md
# LCD Pixel Clock Enable Divider

This block derives the pixel-rate clock enable for an LCD controller from the system clock. Two byte-wide configuration registers sit on a simple write-only bus. The display control register carries the gray-level mode. The clock select register carries the data-bus width mode and a 4-bit divide code. From these the block works out a divide ratio. Each bus width has its own ratio series. Fast black/white mode adds a fixed ×8 divide on top of the series.

When the system clock runs from the slow 32 kHz oscillator, the divide code and the gray mode no longer set the rate. The enable is then asserted on every system clock cycle. A configuration error flag rises if the gray mode is not fast black/white while the slow source is active. The output is a one-cycle enable pulse, not a derived clock. Any accepted register write restarts the divide counter, so no short period can follow a reconfiguration.

Top module: `lcd_clk_div`

## Requirements
- R1: While rst_ni is low, pix_en_o is 0, gray_mode_o is 00 (the display control register resets to 0x80, where bits 3:2 hold the gray mode) and bus_mode_o is 00.
- R2: A write to address 0x047 loads gray_mode_o from wr_data_i[3:2]. A write to address 0x048 loads bus_mode_o from wr_data_i[5:4] and the divide code from wr_data_i[3:0]. Writes to any other address change no output.
- R3: In 1-bit bus mode (bus_mode_o = 00), divide codes 0, 1, 2 and 3 give ratios 1, 2, 8 and 16. Codes 4 to 15 give 16.
- R4: In 4-bit bus mode (01), code c from 0 to 13 gives ratio 2·(c+2). Codes 14 and 15 give 30.
- R5: In 8-bit bus mode (10 or 11), code c from 0 to 13 gives ratio 16·(c+2). Codes 14 and 15 give 240. Bus modes 10 and 11 behave the same.
- R6: In fast black/white mode (gray mode 11), the ratio of R3 to R5 is multiplied by 8. The gray codes 00 (black/white), 01 (4 gray) and 10 (16 gray) leave it unchanged.
- R7: While src_slow_i is 1, pix_en_o is high on every cycle, whatever the divide code and gray mode are. The exception is the cycle after a register write.
- R8: For a ratio N > 1, pix_en_o is a single-cycle pulse with a period of exactly N cycles.
- R9: cfg_err_o is 1 exactly when src_slow_i is 1 and gray_mode_o is not 11.
- R10: A write to either register address restarts the divide. The cycle after the write has no pulse, and the first pulse follows N clock edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| src_slow_i | input | 1 | System clock is the 32 kHz source |
| pix_en_o | output | 1 | Pixel clock enable pulse |
| gray_mode_o | output | 2 | Decoded gray-level mode |
| bus_mode_o | output | 2 | Decoded data-bus width mode |
| cfg_err_o | output | 1 | Slow source active without fast black/white mode |

## Verification
The bound checker watches several rules on every cycle:
- the reset values;
- the register loads and the ignoring of writes to other addresses;
- the enable held high on the slow source;
- the one-cycle pulse width;
- the restart after a write.

The ratio tables of each bus mode, the ×8 fast black/white factor, the saturation of unused codes and the error flag depend on the exact period for each code. Only the bench's directed scenarios show these: each one measures the distance from the write to the first pulse and from that pulse to the next.

// File: rtl/lcd_clk_pkg.sv
package lcd_clk_pkg;

  typedef enum logic [1:0] {
    GRAY_BW   = 2'b00,
    GRAY_4    = 2'b01,
    GRAY_16   = 2'b10,
    GRAY_FAST = 2'b11
  } gray_mode_e;

  typedef enum logic [1:0] {
    BUS_1B   = 2'b00,
    BUS_4B   = 2'b01,
    BUS_8B   = 2'b10,
    BUS_8B_X = 2'b11
  } bus_mode_e;

  localparam int unsigned SEL_W     = 4;
  localparam int unsigned WIDE_LAST = 13;  // last code on a linear ratio series
  localparam int unsigned W4_STEP   = 2;
  localparam int unsigned W8_STEP   = 16;
  localparam int unsigned MAX_BASE  = W8_STEP * (WIDE_LAST + 2);

  typedef struct packed {
    gray_mode_e       gray;
    bus_mode_e        bus;
    logic [SEL_W-1:0] sel;
  } lcd_cfg_t;

endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
  import lcd_clk_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h047,
  parameter logic [ADDR_W-1:0] CLK_ADDR  = 12'h048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output lcd_cfg_t          cfg_o,
  output logic              wr_hit_o
);

  localparam logic [7:0] CTRL_RST = 8'h80;

  logic ctrl_hit, clk_hit;
  logic [7:0] ctrl_q;

  assign ctrl_hit = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign clk_hit  = wr_en_i && (wr_addr_i == CLK_ADDR);
  assign wr_hit_o = ctrl_hit || clk_hit;

  // full byte kept; only the gray field feeds the divider
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= CTRL_RST;
    else if (ctrl_hit) ctrl_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o.bus <= BUS_1B;
      cfg_o.sel <= '0;
    end else if (clk_hit) begin
      cfg_o.bus <= bus_mode_e'(wr_data_i[5:4]);
      cfg_o.sel <= wr_data_i[SEL_W-1:0];
    end
  end

  assign cfg_o.gray = gray_mode_e'(ctrl_q[3:2]);

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_q[7:4], ctrl_q[1:0]};

endmodule

// File: rtl/lcd_ratio_dec.sv
module lcd_ratio_dec
  import lcd_clk_pkg::*;
#(
  parameter int unsigned FAST_SHIFT = 3,
  parameter int unsigned RATIO_W    = 11
) (
  input  lcd_cfg_t             cfg_i,
  input  logic                 src_slow_i,
  output logic [RATIO_W-1:0]   ratio_o
);

  logic [RATIO_W-1:0] base, scaled, sel_ext;

  assign sel_ext = RATIO_W'(cfg_i.sel);

  always_comb begin
    unique case (cfg_i.bus)
      BUS_1B: begin
        unique case (cfg_i.sel)
          4'd0:    base = RATIO_W'(1);
          4'd1:    base = RATIO_W'(2);
          4'd2:    base = RATIO_W'(8);
          default: base = RATIO_W'(16);
        endcase
      end
      BUS_4B: begin
        if (cfg_i.sel > SEL_W'(WIDE_LAST)) base = RATIO_W'(W4_STEP * (WIDE_LAST + 2));
        else                              base = RATIO_W'(W4_STEP) * (sel_ext + RATIO_W'(2));
      end
      default: begin
        if (cfg_i.sel > SEL_W'(WIDE_LAST)) base = RATIO_W'(W8_STEP * (WIDE_LAST + 2));
        else                              base = RATIO_W'(W8_STEP) * (sel_ext + RATIO_W'(2));
      end
    endcase
  end

  generate
    if (FAST_SHIFT > 0) begin : g_fast
      assign scaled = (cfg_i.gray == GRAY_FAST) ? (base << FAST_SHIFT) : base;
    end else begin : g_nofast
      logic unused_gray;
      assign unused_gray = ^cfg_i.gray;
      assign scaled = base;
    end
  endgenerate

  // slow source bypasses every divide
  assign ratio_o = src_slow_i ? RATIO_W'(1) : scaled;

endmodule

// File: rtl/lcd_en_gen.sv
module lcd_en_gen #(
  parameter int unsigned RATIO_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               en_o,
  output logic [RATIO_W-1:0] cnt_o
);

  logic [RATIO_W-1:0] cnt_q, last;

  assign last  = ratio_i - RATIO_W'(1);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_o  <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      en_o  <= 1'b0;
    end else if (cnt_q >= last) begin  // >= covers a ratio that shrank mid-count
      cnt_q <= '0;
      en_o  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + RATIO_W'(1);
      en_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/lcd_clk_div.sv
module lcd_clk_div
  import lcd_clk_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 12'h047,
  parameter logic [ADDR_W-1:0] CLK_ADDR   = 12'h048,
  parameter int unsigned       FAST_SHIFT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              src_slow_i,
  output logic              pix_en_o,
  output logic [1:0]        gray_mode_o,
  output logic [1:0]        bus_mode_o,
  output logic              cfg_err_o
);

  localparam int unsigned MAX_RATIO = MAX_BASE << FAST_SHIFT;
  localparam int unsigned RATIO_W   = $clog2(MAX_RATIO + 1);

  lcd_cfg_t           cfg;
  logic               wr_hit;
  logic [RATIO_W-1:0] ratio_w, cnt_w;

  lcd_cfg_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CLK_ADDR(CLK_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cfg_o(cfg), .wr_hit_o(wr_hit)
  );

  lcd_ratio_dec #(
    .FAST_SHIFT(FAST_SHIFT), .RATIO_W(RATIO_W)
  ) u_dec (
    .cfg_i(cfg), .src_slow_i(src_slow_i), .ratio_o(ratio_w)
  );

  lcd_en_gen #(
    .RATIO_W(RATIO_W)
  ) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(wr_hit), .ratio_i(ratio_w),
    .en_o(pix_en_o), .cnt_o(cnt_w)
  );

  assign gray_mode_o = cfg.gray;
  assign bus_mode_o  = cfg.bus;
  assign cfg_err_o   = src_slow_i && (cfg.gray != GRAY_FAST);

endmodule

// File: rtl/lcd_clk_div_chk.sv
module lcd_clk_div_chk #(
  parameter int unsigned       ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h047,
  parameter logic [ADDR_W-1:0] CLK_ADDR  = 12'h048,
  parameter int unsigned       RATIO_W   = 11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [7:0]         wr_data_i,
  input logic               src_slow_i,
  input logic               pix_en_o,
  input logic [1:0]         gray_mode_o,
  input logic [1:0]         bus_mode_o,
  input logic [RATIO_W-1:0] ratio_w,
  input logic [RATIO_W-1:0] cnt_w
);

  logic armed;
  logic ctrl_wr, clk_wr, any_hit, other_wr;

  assign ctrl_wr  = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign clk_wr   = wr_en_i && (wr_addr_i == CLK_ADDR);
  assign any_hit  = ctrl_wr || clk_wr;
  assign other_wr = wr_en_i && !any_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R1
  reset_val_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!pix_en_o && gray_mode_o == 2'b00 && bus_mode_o == 2'b00));

  // R2
  ctrl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> gray_mode_o == $past(wr_data_i[3:2]));

  // R2
  clk_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_wr |=> bus_mode_o == $past(wr_data_i[5:4]));

  // R2
  other_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_wr |=> ($stable(gray_mode_o) && $stable(bus_mode_o)));

  // R7
  slow_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(src_slow_i) && !$past(any_hit)) |-> pix_en_o);

  // R8
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && pix_en_o && ratio_w != 1) |=> !pix_en_o);

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit |=> (!pix_en_o && cnt_w == '0));

endmodule

bind lcd_clk_div lcd_clk_div_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CLK_ADDR(CLK_ADDR), .RATIO_W(RATIO_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .src_slow_i(src_slow_i), .pix_en_o(pix_en_o),
  .gray_mode_o(gray_mode_o), .bus_mode_o(bus_mode_o), .ratio_w(ratio_w), .cnt_w(cnt_w)
);

// File: tb/lcd_clk_div_tb_top.sv
`timescale 1ns/1ps
module lcd_clk_div_tb_top;

  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] A_CTRL = 12'h047;
  localparam logic [ADDR_W-1:0] A_CLK  = 12'h048;
  localparam int LIMIT = 5000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic src_slow_i = 1'b0;
  logic pix_en_o, cfg_err_o;
  logic [1:0] gray_mode_o, bus_mode_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  lcd_clk_div dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .src_slow_i(src_slow_i), .pix_en_o(pix_en_o),
    .gray_mode_o(gray_mode_o), .bus_mode_o(bus_mode_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ratio(input int bus, input int sel, input int gray, input bit slow);
    int r;
    if (slow) return 1;
    if (bus == 0) begin
      if (sel == 0) r = 1; else if (sel == 1) r = 2; else if (sel == 2) r = 8; else r = 16;
    end else if (bus == 1) r = (sel > 13) ? 30 : 2 * (sel + 2);
    else r = (sel > 13) ? 240 : 16 * (sel + 2);
    if (gray == 3) r = r * 8;
    return r;
  endfunction

  // returns at the falling edge after the write edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // edges until next pulse, sampled on falling edges
  task automatic edges_to_pulse(output int k);
    k = 0;
    do begin
      @(negedge clk_i);
      k++;
    end while (!pix_en_o && k < LIMIT);
  endtask

  task automatic measure(input int expr, input string req);
    int k1, k2;
    chk(pix_en_o == 1'b0, req, pix_en_o, 0);
    edges_to_pulse(k1);
    chk(k1 == expr, req, k1, expr);
    edges_to_pulse(k2);
    chk(k2 == expr, req, k2, expr);
  endtask

  task automatic cfg_run(input int bus, input int sel, input int gray, input string req);
    wr(A_CTRL, 8'h80 | 8'(gray << 2));
    wr(A_CLK, 8'((bus << 4) | sel));
    measure(exp_ratio(bus, sel, gray, src_slow_i), req);
  endtask

  task automatic t_reset;
    chk(pix_en_o == 0, "R1 pix_en", pix_en_o, 0);
    chk(gray_mode_o == 0, "R1 gray", gray_mode_o, 0);
    chk(bus_mode_o == 0, "R1 bus", bus_mode_o, 0);
    chk(cfg_err_o == 0, "R9 reset", cfg_err_o, 0);
  endtask

  task automatic t_regs;
    wr(A_CTRL, 8'h08);
    chk(gray_mode_o == 2'b10, "R2 ctrl load", gray_mode_o, 2);
    wr(A_CLK, 8'h1A);
    chk(bus_mode_o == 2'b01, "R2 clk load", bus_mode_o, 1);
    wr(12'h046, 8'h0C);
    wr(12'h049, 8'h30);
    wr(12'h147, 8'h04);
    chk(gray_mode_o == 2'b10, "R2 other addr gray", gray_mode_o, 2);
    chk(bus_mode_o == 2'b01, "R2 other addr bus", bus_mode_o, 1);
    wr(A_CTRL, 8'h00);
    wr(A_CLK, 8'h1A);
    measure(2 * (10 + 2), "R2 sel kept");
  endtask

  task automatic t_bus1;
    for (int s = 0; s < 16; s++) cfg_run(0, s, 0, "R3 bus1");
  endtask

  task automatic t_bus4;
    for (int s = 0; s < 16; s++) cfg_run(1, s, 1, "R4 bus4");
  endtask

  task automatic t_bus8;
    for (int s = 0; s < 16; s++) cfg_run(2, s, 2, "R5 bus8");
    cfg_run(3, 0, 0, "R5 bus8 alt");
    cfg_run(3, 15, 0, "R5 bus8 alt sat");
  endtask

  task automatic t_fast;
    cfg_run(0, 0, 3, "R6 fast 1b");
    cfg_run(0, 3, 3, "R6 fast 1b 16");
    cfg_run(1, 5, 3, "R6 fast 4b");
    cfg_run(2, 15, 3, "R6 fast 8b max");
    cfg_run(1, 5, 2, "R6 16gray no extra");
  endtask

  task automatic t_width;
    cfg_run(0, 1, 0, "R8 ratio2");
    @(negedge clk_i);
    chk(pix_en_o == 1'b0, "R8 width", pix_en_o, 0);
  endtask

  task automatic t_slow;
    int hi;
    src_slow_i = 1'b1;
    cfg_run(2, 9, 3, "R7 slow fast");
    chk(cfg_err_o == 0, "R9 slow fast", cfg_err_o, 0);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (pix_en_o) hi++;
    end
    chk(hi == 20, "R7 slow steady", hi, 20);
    cfg_run(1, 13, 0, "R7 slow bw");
    chk(cfg_err_o == 1, "R9 slow bw", cfg_err_o, 1);
    wr(A_CTRL, 8'h04);
    chk(cfg_err_o == 1, "R9 slow 4g", cfg_err_o, 1);
    src_slow_i = 1'b0;
    #1;
    chk(cfg_err_o == 0, "R9 fast src", cfg_err_o, 0);
  endtask

  task automatic t_restart;
    wr(A_CTRL, 8'h00);
    wr(A_CLK, 8'h03);
    repeat (5) @(negedge clk_i);
    wr(A_CLK, 8'h03);
    measure(16, "R10 restart mid count");
    repeat (3) @(negedge clk_i);
    wr(A_CTRL, 8'h0C);
    measure(128, "R10 restart on ctrl");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_regs();
    t_bus1();
    t_bus4();
    t_bus8();
    t_fast();
    t_width();
    t_slow();
    t_restart();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule